// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the memory side of subroutine linkage for a small 32-bit CPU. Register 0 serves as the frame pointer and register 1 as the stack pointer. The decode stage hands over a call or return command along with the current PC, the length of the calling instruction, the call target and the present frame and stack pointer values. The sequencer then makes the required word accesses through a single-port memory request interface that has a ready handshake. When it has finished, it returns the new frame pointer, stack pointer and PC on a one-cycle completion pulse.

Each frame has three words. The old frame pointer sits at the lowest address, the return address one word above it, and a reserved static-chain word above that. A call therefore moves the stack pointer down by 12 bytes. A return rebuilds the stack pointer from the frame pointer and finishes 12 bytes above it. The register file and the rest of the datapath are outside this block; the caller writes the three returned values into its registers on the completion pulse.

Top module: `frame_sequencer`

## Requirements
- R1: While reset is held and after its release, `done`, `busy` and `mem_req` are 0, and `upd_fp`, `upd_sp` and `upd_pc` read 0.
- R2: On an accepted call, the first access is a write of `cmd_pc + cmd_len` to address `sp_in - 8`.
- R3: The second access of a call is a write of `fp_in` to address `sp_in - 12`.
- R4: At the end of a call, `upd_sp` and `upd_fp` both equal `sp_in - 12`, and `upd_pc` equals `cmd_target`.
- R5: On an accepted return, the first access is a read at `fp_in`, and the word read becomes `upd_fp`.
- R6: The second access of a return is a read at `fp_in + 4`. The word read becomes `upd_pc`, and `upd_sp` equals `fp_in + 12`.
- R7: Each access keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stable until a cycle with `mem_ready` high, however many cycles that takes.
- R8: A command is accepted when `cmd_valid` is high in a cycle where `busy` is low. `busy` is high from the next cycle until the result is ready. `done` is a single-cycle pulse one cycle after the ready of the second access, with `busy` low in that cycle. With ready delays of d cycles, `done` is seen 3+2d cycles after the command.
- R9: A command presented while `busy` is high is ignored. It causes no extra access and does not change the result of the operation in flight.
- R10: A command presented in the same cycle as `done` is accepted, so operations can run back to back.
- R11: All address arithmetic wraps modulo 2^32.
- R12: `mem_we` is 1 on both call accesses and 0 on both return accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_is_call | input | 1 | 1 = call, 0 = return |
| cmd_target | input | 32 | Call destination |
| cmd_pc | input | 32 | Address of the calling instruction |
| cmd_len | input | 4 | Byte length of the calling instruction |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| upd_fp | output | 32 | New frame pointer |
| upd_sp | output | 32 | New stack pointer |
| upd_pc | output | 32 | New PC |

## Verification
The completion pulse of one operation can fall in the same cycle as the acceptance of the next command. To provoke this, `cmd_valid` is held high across a whole operation with the second command's fields already driven. Any earlier presentation of that command lands while `busy` is high and must be dropped. The bench judges the overlap in three ways. The first result must match its own expected values. `busy` must be high in the cycle after `done`. Exactly four accesses must follow, with the second operation's expected addresses and results.

// File: rtl/frame_seq_pkg.sv
// Shared types for the call/return frame sequencer.
// Assumes: one operation at a time; phases are visited in a fixed order.
package frame_seq_pkg;

    // Sequencer phase; each non-idle phase owns exactly one memory access.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CALL_RA = 3'd1,
        PH_CALL_FP = 3'd2,
        PH_RET_FP  = 3'd3,
        PH_RET_PC  = 3'd4
    } phase_t;

endpackage

// File: rtl/frame_fsm.sv
// Phase controller for the frame sequencer.
// Accepts a command only in idle, advances one phase per completed
// memory access, and flags the access that finishes the operation.
// Assumes: mem_ready is only meaningful while a request is outstanding.
module frame_fsm
    import frame_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  logic   cmd_is_call,
    input  logic   mem_ready,
    output phase_t phase,
    output logic   accept,
    output logic   fp_beat,
    output logic   final_beat
);

    phase_t phase_nx;

    // Command acceptance and beat qualifiers.
    always_comb begin
        accept     = (phase == PH_IDLE) && cmd_valid;
        fp_beat    = mem_ready && (phase == PH_RET_FP);
        final_beat = mem_ready && ((phase == PH_CALL_FP) || (phase == PH_RET_PC));
    end

    // Next-phase selection; waits in place until the access is ready.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:    if (cmd_valid) phase_nx = cmd_is_call ? PH_CALL_RA : PH_RET_FP;
            PH_CALL_RA: if (mem_ready) phase_nx = PH_CALL_FP;
            PH_CALL_FP: if (mem_ready) phase_nx = PH_IDLE;
            PH_RET_FP:  if (mem_ready) phase_nx = PH_RET_PC;
            PH_RET_PC:  if (mem_ready) phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !mem_ready) |=> $stable(phase)); // R7

endmodule

// File: rtl/frame_addr_calc.sv
// Access generator for the frame sequencer.
// Maps the current phase and captured operands to one memory access,
// and computes the stack pointer that each kind of operation leaves.
// Assumes: operands are held stable for the whole operation.
module frame_addr_calc
    import frame_seq_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int WORD_BYTES  = 4,
    parameter int CHAIN_SLOTS = 1
) (
    input  phase_t            phase,
    input  logic [XLEN-1:0]   fp_q,
    input  logic [XLEN-1:0]   sp_q,
    input  logic [XLEN-1:0]   ret_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [XLEN-1:0]   call_sp,
    output logic [XLEN-1:0]   ret_sp
);

    localparam int RA_DROP     = (CHAIN_SLOTS + 1) * WORD_BYTES;
    localparam int FRAME_BYTES = RA_DROP + WORD_BYTES;
    localparam logic [XLEN-1:0] RA_DROP_V = XLEN'(RA_DROP);
    localparam logic [XLEN-1:0] FRAME_V   = XLEN'(FRAME_BYTES);
    localparam logic [XLEN-1:0] WORD_V    = XLEN'(WORD_BYTES);

    // Stack pointer left behind by a call and by a return.
    always_comb begin
        call_sp = sp_q - FRAME_V;
        ret_sp  = fp_q + FRAME_V;
    end

    // One access per phase: two pushes for a call, two pops for a return.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (phase)
            PH_CALL_RA: begin mem_we = 1'b1; mem_addr = sp_q - RA_DROP_V; mem_wdata = ret_q; end
            PH_CALL_FP: begin mem_we = 1'b1; mem_addr = call_sp;          mem_wdata = fp_q;  end
            PH_RET_FP:  mem_addr = fp_q;
            PH_RET_PC:  mem_addr = fp_q + WORD_V;
            default:    mem_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/frame_sequencer.sv
// Call/return frame sequencer top.
// Captures a command in idle, runs two word accesses through frame_fsm and
// frame_addr_calc, and presents new FP, SP and PC with a one-cycle done.
// Assumes: the register file writes upd_* on done; fp_in/sp_in are
// current when cmd_valid is high.
module frame_sequencer
    import frame_seq_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int LEN_W       = 4,
    parameter int WORD_BYTES  = 4,
    parameter int CHAIN_SLOTS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_is_call,
    input  logic [XLEN-1:0]  cmd_target,
    input  logic [XLEN-1:0]  cmd_pc,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [XLEN-1:0]  fp_in,
    input  logic [XLEN-1:0]  sp_in,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic             done,
    output logic [XLEN-1:0]  upd_fp,
    output logic [XLEN-1:0]  upd_sp,
    output logic [XLEN-1:0]  upd_pc
);

    localparam int FRAME_BYTES = (CHAIN_SLOTS + 2) * WORD_BYTES;

    phase_t          phase;
    logic            accept, fp_beat, final_beat;
    logic            call_q;
    logic [XLEN-1:0] fp_q, sp_q, ret_q, tgt_q, loaded_fp;
    logic [XLEN-1:0] call_sp, ret_sp;

    frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_is_call(cmd_is_call),
        .mem_ready  (mem_ready),
        .phase      (phase),
        .accept     (accept),
        .fp_beat    (fp_beat),
        .final_beat (final_beat)
    );

    frame_addr_calc #(
        .XLEN       (XLEN),
        .WORD_BYTES (WORD_BYTES),
        .CHAIN_SLOTS(CHAIN_SLOTS)
    ) u_addr (
        .phase    (phase),
        .fp_q     (fp_q),
        .sp_q     (sp_q),
        .ret_q    (ret_q),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .call_sp  (call_sp),
        .ret_sp   (ret_sp)
    );

    // Busy whenever an access phase is active.
    always_comb busy = (phase != PH_IDLE);

    // Operand capture on acceptance; return address formed once here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_q <= 1'b0;
            fp_q   <= '0;
            sp_q   <= '0;
            ret_q  <= '0;
            tgt_q  <= '0;
        end else if (accept) begin
            call_q <= cmd_is_call;
            fp_q   <= fp_in;
            sp_q   <= sp_in;
            ret_q  <= cmd_pc + {{(XLEN-LEN_W){1'b0}}, cmd_len};
            tgt_q  <= cmd_target;
        end
    end

    // Holds the frame pointer popped by the first return access.
    always_ff @(posedge clk) begin
        if (!rst_n)       loaded_fp <= '0;
        else if (fp_beat) loaded_fp <= mem_rdata;
    end

    // Result registers and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            upd_fp <= '0;
            upd_sp <= '0;
            upd_pc <= '0;
        end else begin
            done <= final_beat;
            if (final_beat) begin
                upd_sp <= call_q ? call_sp : ret_sp;
                upd_fp <= call_q ? call_sp : loaded_fp;
                upd_pc <= call_q ? tgt_q   : mem_rdata;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done)); // R8

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && call_q) |-> (upd_fp == upd_sp)); // R4

    AST_RET_UNWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !call_q) |-> (upd_sp == fp_q + XLEN'(FRAME_BYTES))); // R6

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(tgt_q) && $stable(ret_q) && $stable(sp_q))); // R9

    AST_WE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_we == call_q)); // R12

endmodule

// File: tb/frame_sequencer_test.sv
module frame_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_is_call = 1'b0;
    logic [31:0] cmd_target = '0, cmd_pc = '0, fp_in = '0, sp_in = '0;
    logic [3:0]  cmd_len = '0;
    logic        busy, mem_req, mem_we, done;
    logic [31:0] mem_addr, mem_wdata, upd_fp, upd_sp, upd_pc;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    frame_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_call(cmd_is_call),
        .cmd_target(cmd_target), .cmd_pc(cmd_pc), .cmd_len(cmd_len),
        .fp_in(fp_in), .sp_in(sp_in), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
        .upd_fp(upd_fp), .upd_sp(upd_sp), .upd_pc(upd_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: ready after delay_cfg waiting cycles, reads return ~addr.
    int          delay_cfg = 0;
    int          wait_cnt  = 0;
    logic [31:0] first_addr = '0;
    logic [31:0] log_addr [8];
    logic [31:0] log_wd   [8];
    logic        log_we   [8];
    int          log_n = 0;

    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt == 0) first_addr = mem_addr;
            else check("R7 address held while waiting", mem_addr, first_addr);
            if (wait_cnt >= delay_cfg) begin
                mem_ready = 1'b1;
                mem_rdata = ~mem_addr;
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_wd[log_n]   = mem_wdata;
                    log_we[log_n]   = mem_we;
                end
                log_n++;
                wait_cnt = 0;
            end else begin
                mem_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: an expired run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    // Waits for done (already counted negedges passed in); returns the total.
    task automatic wait_done(inout int n);
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (!done) check("R8 done never arrived", 32'd0, 32'd1);
    endtask

    task automatic run_op(input bit is_call, input logic [31:0] sp, input logic [31:0] fp,
                          input logic [31:0] pc, input logic [3:0] len,
                          input logic [31:0] tgt, input int d, input bit intrude);
        int n;
        delay_cfg = d;
        log_n = 0;
        cmd_is_call = is_call; sp_in = sp; fp_in = fp; cmd_pc = pc; cmd_len = len; cmd_target = tgt;
        cmd_valid = 1'b1;
        @(negedge clk);
        n = 1;
        cmd_valid = 1'b0;
        check("R8 busy after accept", {31'd0, busy}, 32'd1);
        if (intrude) begin
            // R9: a different command offered while busy
            cmd_is_call = ~is_call; sp_in = ~sp; fp_in = ~fp; cmd_pc = 32'h0BAD_0000; cmd_target = ~tgt;
            cmd_valid = 1'b1;
            @(negedge clk);
            n++;
            cmd_valid = 1'b0;
        end
        wait_done(n);
        check("R8 done latency", n, 3 + 2 * d);
        check("R8 busy low with done", {31'd0, busy}, 32'd0);
        check("R9 access count", log_n, 2);
        if (is_call) begin
            check("R2 first access address", log_addr[0], sp - 32'd8);
            check("R2 return address written", log_wd[0], pc + {28'd0, len});
            check("R12 first call access writes", {31'd0, log_we[0]}, 32'd1);
            check("R3 second access address", log_addr[1], sp - 32'd12);
            check("R3 old frame pointer written", log_wd[1], fp);
            check("R12 second call access writes", {31'd0, log_we[1]}, 32'd1);
            check("R4 new sp", upd_sp, sp - 32'd12);
            check("R4 new fp", upd_fp, sp - 32'd12);
            check("R4 new pc", upd_pc, tgt);
            if (sp < 32'd12) check("R11 call wraps", upd_sp, 32'hFFFF_FFFF - (32'd11 - sp));
        end else begin
            check("R5 first access address", log_addr[0], fp);
            check("R12 first return access reads", {31'd0, log_we[0]}, 32'd0);
            check("R5 new fp from memory", upd_fp, ~fp);
            check("R6 second access address", log_addr[1], fp + 32'd4);
            check("R12 second return access reads", {31'd0, log_we[1]}, 32'd0);
            check("R6 new pc from memory", upd_pc, ~(fp + 32'd4));
            check("R6 new sp", upd_sp, fp + 32'd12);
            if (fp > 32'hFFFF_FFF3) check("R11 return wraps", upd_sp, fp - 32'hFFFF_FFF4);
        end
        @(negedge clk);
        check("R8 done is one cycle", {31'd0, done}, 32'd0);
    endtask

    logic [31:0] spv [4];
    logic [31:0] fpv [4];

    initial begin
        int n;
        spv = '{32'h0000_1000, 32'h0000_0004, 32'hFFFF_FFF0, 32'h8000_0008};
        fpv = '{32'h0000_2000, 32'hFFFF_FFF8, 32'h0000_0000, 32'h1234_5678};

        repeat (3) @(negedge clk);
        check("R1 done in reset", {31'd0, done}, 32'd0);
        check("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 upd_fp after reset", upd_fp, 32'd0);
        check("R1 upd_sp after reset", upd_sp, 32'd0);
        check("R1 upd_pc after reset", upd_pc, 32'd0);

        for (int d = 0; d < 4; d++) begin
            for (int v = 0; v < 4; v++) begin
                run_op(1'b1, spv[v], fpv[v], 32'h0000_0100 + 32'(v * 16),
                       (v % 2 == 0) ? 4'd6 : 4'd2, 32'hC000_0000 + 32'(v), d, d > 0);
                run_op(1'b0, spv[v], fpv[v], 32'h0, 4'd0, 32'h0, d, d > 0);
            end
        end

        // R10: hold the next command through the first operation.
        delay_cfg = 1;
        log_n = 0;
        cmd_is_call = 1'b1; sp_in = 32'h0000_4000; fp_in = 32'h0000_5000;
        cmd_pc = 32'h0000_0200; cmd_len = 4'd6; cmd_target = 32'h0000_9000;
        cmd_valid = 1'b1;
        @(negedge clk);
        n = 1;
        cmd_is_call = 1'b0; fp_in = 32'h0000_3FF4; sp_in = 32'h0;
        wait_done(n);
        check("R10 first result pc", upd_pc, 32'h0000_9000);
        check("R10 first result sp", upd_sp, 32'h0000_3FF4);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 accepted with done", {31'd0, busy}, 32'd1);
        n = 1;
        wait_done(n);
        check("R10 total accesses", log_n, 4);
        check("R10 second read address", log_addr[2], 32'h0000_3FF4);
        check("R10 second fp", upd_fp, ~32'h0000_3FF4);
        check("R10 second pc", upd_pc, ~32'h0000_3FF8);
        check("R10 second sp", upd_sp, 32'h0000_4000);
        @(negedge clk);

        summary();
        $finish;
    end

endmodule